// File: doc/BRIEF.md
# Windowed Watchdog Timer with Programmable Ratio

This block watches a periodic feed written by software. A prescaler divides the clock into a base tick. A programmable short period is the base period shifted left by a 3-bit select. The long period is the short period shifted left once more, by the ratio plus one. If no feed is accepted within the long period, the watchdog faults. In window mode it also faults when a feed comes too early, before the short period has run since the last restart. In slow mode only the long period is checked.

A fault either gives a one-cycle reset pulse or sets a sticky interrupt flag, as a configuration bit selects. After any fault the elapsed count starts again from zero. Timing fields written while the watchdog runs are only staged. They take effect at the next restart, so a period in progress never changes length. Only enable value 1 runs the watchdog. The other enable values hold it stopped.

Top module: `window_watchdog`

## Requirements
- R1: After reset both `rstPulse` and `irqFlag` are low and the watchdog is disabled.
- R2: Register map, written when `wrEn` is high. Address 0 is config: bits 1:0 enable, bit 2 slow type, bit 3 reset action. Address 1 is timeout: bits 6:4 short select, bits 1:0 ratio. Address 2 is feed: bit 0 set is a feed. Address 3 is status: writing bit 0 set clears the interrupt flag, and writing 0 does nothing.
- R3: The base tick is PRESCALE clocks. The short period is S = PRESCALE·2^sel clocks. The long period is L = S·2^(ratio+1) clocks. This holds up to sel 7 with ratio 3.
- R4: Take a restart sampled on clock edge E. If no feed is accepted afterwards, a fault appears at the outputs just after edge E+L.
- R5: In window mode (type 0), a feed sampled on an edge at most S clocks after the restart edge is early. It faults at that same edge. A later feed is accepted and restarts the count.
- R6: In slow mode (type 1), every feed while running is accepted, whatever its timing.
- R7: With the reset action selected, each fault gives `rstPulse` high for exactly one cycle.
- R8: With the interrupt action selected, a fault sets `irqFlag`. The flag stays set until a status clear. If a fault and a clear come in the same cycle, the fault wins.
- R9: A fault restarts the elapsed count, so repeated faults come every L clocks while no feed arrives.
- R10: Enable values 0, 2 and 3 keep the count stopped, ignore feeds and raise no fault.
- R11: Timeout and type writes made while running take effect only at the next restart (feed, fault or enable).
- R12: Writing enable 1 while stopped starts the count from zero at the edge of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 7 | Register write data |
| rstPulse | output | 1 | One-cycle fault reset pulse |
| irqFlag | output | 1 | Sticky fault interrupt flag |

## Verification
The assertions assume that a write lasts one cycle and carries a defined address and data. They also assume that reset is held long enough to clear every register. The stimulus only drives inputs at the falling edge, one register write per cycle, with `wrEn` low in between, so every write is seen exactly once. The assertions on period stability and the elapsed-count bound depend on the enable field changing only through config writes. The bench places disables away from expected fault edges, so that no disable meets a fault in the same cycle.

// File: rtl/wwd_pkg.sv
`timescale 1ns/1ps
package wwd_pkg;
  localparam int DATA_W  = 7;
  localparam int ADDR_W  = 2;
  localparam int SEL_W   = 3;
  localparam int RATIO_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_TMO  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FEED = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  localparam int CFG_SLOW_BIT  = 2;
  localparam int CFG_RST_BIT   = 3;
  localparam int TMO_SHORT_LSB = 4;
  localparam logic [1:0] EN_RUN = 2'd1;

  // control -> datapath strobes and next timing fields
  typedef struct packed {
    logic               run;
    logic               clear;
    logic               slow;
    logic [SEL_W-1:0]   shortSel;
    logic [RATIO_W-1:0] ratio;
  } dpCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic pastShort;
    logic longHit;
    logic slowAct;
  } dpStat_t;
endpackage

// File: rtl/wwd_dp.sv
`timescale 1ns/1ps
module wwd_dp import wwd_pkg::*; #(
  parameter int PRESCALE = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCmd_t  cmd,
  output dpStat_t stat
);
  localparam int PW        = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int MAX_SHIFT = (1 << SEL_W) - 1 + (1 << RATIO_W);
  localparam int EW        = MAX_SHIFT + 1;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);

  logic [PW-1:0]      preCnt;
  logic [EW-1:0]      elapsed;
  logic [SEL_W-1:0]   actShort;
  logic [RATIO_W-1:0] actRatio;
  logic               actSlow;
  logic               tick;
  logic [SH_W-1:0]    longShift;
  logic [EW-1:0]      shortTicks;
  logic [EW-1:0]      longTicks;

  always_comb begin
    tick       = (preCnt == PW'(PRESCALE - 1));
    longShift  = SH_W'(actShort) + SH_W'(actRatio) + SH_W'(1);
    shortTicks = EW'(1) << actShort;
    longTicks  = EW'(1) << longShift;
    stat.pastShort = (elapsed >= shortTicks);
    stat.longHit   = tick && (elapsed == longTicks - EW'(1));
    stat.slowAct   = actSlow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      elapsed  <= '0;
      actShort <= '0;
      actRatio <= '0;
      actSlow  <= 1'b0;
    end else if (!cmd.run || cmd.clear) begin
      preCnt   <= '0;
      elapsed  <= '0;
      actShort <= cmd.shortSel;
      actRatio <= cmd.ratio;
      actSlow  <= cmd.slow;
    end else begin
      preCnt <= tick ? '0 : preCnt + PW'(1);
      if (tick) elapsed <= elapsed + EW'(1);
    end
  end

  // R4
  elapsed_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.run |-> (elapsed < longTicks));

  // R11
  params_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !cmd.clear) |=> $stable({actShort, actRatio, actSlow}));
endmodule

// File: rtl/wwd_ctrl.sv
`timescale 1ns/1ps
module wwd_ctrl import wwd_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output logic              rstPulse,
  output logic              irqFlag
);
  logic [1:0]         cfgEn;
  logic               cfgSlow;
  logic               cfgRst;
  logic [SEL_W-1:0]   tmoShort;
  logic [RATIO_W-1:0] tmoRatio;
  logic wrCfg, wrTmo, feedReq, clrReq;
  logic running, feedOk, earlyFeed, longFault, fault;

  always_comb begin
    wrCfg   = wrEn && (wrAddr == ADDR_CFG);
    wrTmo   = wrEn && (wrAddr == ADDR_TMO);
    feedReq = wrEn && (wrAddr == ADDR_FEED) && wrData[0];
    clrReq  = wrEn && (wrAddr == ADDR_STAT) && wrData[0];
    running = (cfgEn == EN_RUN);
    feedOk    = running && feedReq && (stat.slowAct || stat.pastShort);
    earlyFeed = running && feedReq && !stat.slowAct && !stat.pastShort;
    longFault = running && stat.longHit && !feedOk;
    fault     = earlyFeed || longFault;
    cmd.run      = running;
    cmd.clear    = feedOk || fault;
    cmd.slow     = wrCfg ? wrData[CFG_SLOW_BIT] : cfgSlow;
    cmd.shortSel = wrTmo ? wrData[TMO_SHORT_LSB +: SEL_W] : tmoShort;
    cmd.ratio    = wrTmo ? wrData[RATIO_W-1:0] : tmoRatio;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn    <= '0;
      cfgSlow  <= 1'b0;
      cfgRst   <= 1'b0;
      tmoShort <= '0;
      tmoRatio <= '0;
      rstPulse <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      if (wrCfg) begin
        cfgEn   <= wrData[1:0];
        cfgSlow <= wrData[CFG_SLOW_BIT];
        cfgRst  <= wrData[CFG_RST_BIT];
      end
      if (wrTmo) begin
        tmoShort <= wrData[TMO_SHORT_LSB +: SEL_W];
        tmoRatio <= wrData[RATIO_W-1:0];
      end
      rstPulse <= fault && cfgRst;
      irqFlag  <= (fault && !cfgRst) || (irqFlag && !clrReq);
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !irqFlag) |=> (!rstPulse && !irqFlag));

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !clrReq) |=> irqFlag);

  // R7
  rst_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> $past(cfgRst));

  // R5
  early_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && feedReq && !stat.slowAct && !stat.pastShort) |=> (rstPulse || irqFlag));
endmodule

// File: rtl/window_watchdog.sv
`timescale 1ns/1ps
module window_watchdog #(
  parameter int PRESCALE = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [6:0] wrData,
  output logic       rstPulse,
  output logic       irqFlag
);
  wwd_pkg::dpCmd_t  cmd;
  wwd_pkg::dpStat_t stat;

  wwd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stat(stat), .cmd(cmd), .rstPulse(rstPulse), .irqFlag(irqFlag)
  );

  wwd_dp #(.PRESCALE(PRESCALE)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stat(stat)
  );
endmodule

// File: tb/window_watchdog_tb.sv
`timescale 1ns/1ps
module window_watchdog_tb;
  localparam int P = 4;

  typedef struct {
    int    cyc;
    bit    isRst;
    string tag;
  } ev_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [6:0] wrData = '0;
  logic       rstPulse, irqFlag;

  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  int  lastEdge = 0;
  bit  irqPrev = 1'b0;
  bit  done = 1'b0;
  ev_t expQ[$];

  window_watchdog #(.PRESCALE(P)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rstPulse(rstPulse), .irqFlag(irqFlag)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int c, input bit isRst, input string tag);
    ev_t e;
    e.cyc = c; e.isRst = isRst; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic popCmp(input bit isRst);
    ev_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R10 unexpected fault", cyc, -1);
    end else begin
      e = expQ.pop_front();
      check(e.cyc == cyc && e.isRst == isRst, e.tag, cyc, e.cyc);
    end
  endtask

  // monitor: compares observed fault events against the scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rstPulse) popCmp(1'b1);
      if (irqFlag && !irqPrev) popCmp(1'b0);
      irqPrev = irqFlag;
    end
  end

  // called at a falling edge; the write is sampled on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
    lastEdge = cyc;
  endtask

  task automatic waitEdge(input int n);
    while (cyc < n - 1) @(negedge clk);
  endtask

  task automatic expectDone(input string tag);
    check(expQ.size() == 0, tag, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog timeout, run hung actual=%0d expected=0", cyc);
    finishRun();
  end

  initial begin
    int c, f, f2;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rstPulse == 1'b0, "R1 rstPulse", rstPulse, 0);
    check(irqFlag == 1'b0, "R1 irqFlag", irqFlag, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R12 / R4 / R7 / R9: long timeout from enable, repeated
    wr(2'd1, 7'h10);                 // sel 1, ratio 0 -> L = 16 clocks
    wr(2'd0, 7'h09);                 // run, window, reset action
    c = lastEdge;
    push(c + 16, 1'b1, "R4 R7 R12 long fault");
    push(c + 32, 1'b1, "R9 fault restart");
    waitEdge(c + 35); wr(2'd0, 7'h00);
    expectDone("R9 events seen");

    // R5 accepted feeds in window mode
    wr(2'd0, 7'h09); c = lastEdge;
    waitEdge(c + 10); wr(2'd2, 7'h01); f = lastEdge;
    waitEdge(f + 12); wr(2'd2, 7'h01); f2 = lastEdge;
    push(f2 + 16, 1'b1, "R5 fault after last good feed");
    waitEdge(f2 + 18); wr(2'd0, 7'h00);
    expectDone("R5 window feeds");

    // R5 boundary: S clocks is early, S+1 is accepted
    wr(2'd0, 7'h09); c = lastEdge;
    waitEdge(c + 8);
    push(c + 8, 1'b1, "R5 early feed at S");
    wr(2'd2, 7'h01); f = lastEdge;
    waitEdge(f + 9); wr(2'd2, 7'h01); f2 = lastEdge;
    waitEdge(f2 + 4); wr(2'd0, 7'h00);
    expectDone("R5 feed at S+1 accepted");

    // R6 slow mode accepts an immediate feed
    wr(2'd0, 7'h0D); c = lastEdge;
    waitEdge(c + 2); wr(2'd2, 7'h01); f = lastEdge;
    push(f + 16, 1'b1, "R6 slow mode fault");
    waitEdge(f + 18); wr(2'd0, 7'h00);
    expectDone("R6 slow feed");

    // R8 interrupt action, sticky flag, status clear
    wr(2'd0, 7'h01); c = lastEdge;
    push(c + 16, 1'b0, "R8 irq set");
    waitEdge(c + 18); wr(2'd0, 7'h00);
    repeat (5) @(negedge clk);
    check(irqFlag == 1'b1, "R8 irq sticky", irqFlag, 1);
    check(rstPulse == 1'b0, "R8 no reset pulse", rstPulse, 0);
    wr(2'd3, 7'h00);
    check(irqFlag == 1'b1, "R2 status write of 0 keeps flag", irqFlag, 1);
    wr(2'd3, 7'h01);
    check(irqFlag == 1'b0, "R8 irq cleared", irqFlag, 0);
    expectDone("R8 events");

    // R10 enable values 2, 3 and 0 are stopped
    wr(2'd0, 7'h0A); repeat (10) @(negedge clk);
    wr(2'd2, 7'h01); repeat (60) @(negedge clk);
    check(rstPulse == 1'b0, "R10 enable 2 quiet", rstPulse, 0);
    wr(2'd0, 7'h0B); repeat (60) @(negedge clk);
    check(irqFlag == 1'b0, "R10 enable 3 quiet", irqFlag, 0);
    wr(2'd0, 7'h08); wr(2'd2, 7'h01); repeat (40) @(negedge clk);
    expectDone("R10 no faults while stopped");

    // R11 timeout change deferred to next restart
    wr(2'd1, 7'h10);
    wr(2'd0, 7'h09); c = lastEdge;
    waitEdge(c + 5); wr(2'd1, 7'h00);   // L would be 8 clocks
    push(c + 16, 1'b1, "R11 old period kept");
    push(c + 24, 1'b1, "R11 new period after restart");
    waitEdge(c + 26); wr(2'd0, 7'h00);
    expectDone("R11 timeout deferral");

    // R11 type change deferred: still window mode, early feed faults
    wr(2'd1, 7'h10);
    wr(2'd0, 7'h09); c = lastEdge;
    wr(2'd0, 7'h0D);
    waitEdge(c + 4);
    push(c + 4, 1'b1, "R11 type change deferred");
    wr(2'd2, 7'h01);
    waitEdge(c + 7); wr(2'd0, 7'h00);
    expectDone("R11 type deferral");

    // R3 ratio scaling and maximum period
    wr(2'd1, 7'h02);                 // sel 0, ratio 2 -> 32 clocks
    wr(2'd0, 7'h0D); c = lastEdge;
    push(c + 32, 1'b1, "R3 ratio 2");
    waitEdge(c + 34); wr(2'd0, 7'h00);
    wr(2'd1, 7'h73);                 // sel 7, ratio 3 -> 8192 clocks
    wr(2'd0, 7'h0D); c = lastEdge;
    push(c + 8192, 1'b1, "R3 maximum period");
    waitEdge(c + 8194); wr(2'd0, 7'h00);
    expectDone("R3 periods");

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule